// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Lock

This block decides which of several bus masters owns a shared system bus. Each master raises its own request line and receives its own grant line, both active high with one bit per master. The lowest-indexed requester always wins. Master 0 is the default owner: it holds the grant whenever nobody requests, and it is forced onto the bus while reset is applied. The grant is a registered one-hot vector, so it can change at most once per clock and follows the requests one cycle later.

A master that owns the bus can raise its lock bit to keep the grant through a locked transfer. Arbitration is frozen while that bit is high, and lock bits from masters that do not own the bus have no effect. Each master can be built with a hand-over cycle. When the grant moves to such a master, the arbiter first spends one clock with only the default master granted and the `handover` flag high. In that clock the default master must not start a transfer. On the next clock it grants whichever master wins at that point.

Top module: `bus_arbiter`

## Requirements
- R1: Every cycle the grant vector `gnt` (NUM_MASTERS bits, bit i belongs to master i) has exactly one bit set.
- R2: A clock edge with `rst` high leaves `gnt` equal to one-hot master 0 (bit 0 set) and `handover` low, whatever the requests.
- R3: With the owner unlocked and no hand-over in progress, the next `gnt` selects the requester with the lowest index. For six masters, requests 6'b111110 give grant 6'b000010 and requests 6'b011101 give grant 6'b000001.
- R4: With the owner unlocked, no hand-over in progress and `req` all zero, the next `gnt` is one-hot master 0.
- R5: While the owner (the master whose `gnt` bit is set) holds its `lock` bit high outside a hand-over cycle, `gnt` does not change, whatever the requests.
- R6: A `lock` bit from a master that does not own the bus has no effect on the grant decision.
- R7: When the new winner is not the current owner, is not master 0, and its bit in HANDOVER_MASK is set, the next cycle shows `gnt` = one-hot master 0 with `handover` high.
- R8: When the new winner's HANDOVER_MASK bit is clear, the grant moves to it in one clock and `handover` stays low.
- R9: `handover` is never high for two cycles in a row. After a hand-over cycle, `gnt` goes to the winner computed from the requests at the end of that cycle, with no second hand-over.
- R10: `gnt` is registered. A change on `req` does not alter `gnt` until the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_MASTERS | Request line per master, active high |
| lock | input | NUM_MASTERS | Locked-transfer indication per master, active high |
| gnt | output | NUM_MASTERS | One-hot grant per master, registered |
| handover | output | 1 | High during an inserted hand-over cycle |

## Verification
The bench goes after the points where a grant decision is easy to get wrong. One is a low-priority requester that also shows a lock bit without owning the bus; a design that honours foreign locks would freeze on the wrong owner. Another is an owner whose lock stays high while a higher-priority master requests; a design that re-arbitrates here would hand the bus over in the middle of a locked transfer. Hand-overs are checked in both directions. A mask bit that is ignored shows up as a direct jump with no gap cycle. A gap that repeats or lasts too long shows up as `handover` staying high. A gap that latches its target too early is caught by changing the requests during the gap. Reset is applied while a non-default master owns the bus and every request is high; a design whose reset does not win would keep the old owner.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_MAX_MASTERS = 7;

  typedef enum logic {
    PH_OWN = 1'b0,
    PH_GAP = 1'b1
  } arb_phase_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win_oh
);
  // Bit 0 wins when it requests or when nobody requests (default owner).
  assign win_oh[0] = req[0] | ~(|req);

  for (genvar i = 1; i < N; i++) begin : g_pick
    assign win_oh[i] = req[i] & ~(|req[i-1:0]);
  end
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
#(
  parameter int unsigned N = 6,
  parameter logic [N-1:0] HANDOVER_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] win_oh,
  input  logic [N-1:0] lock,
  output logic [N-1:0] gnt,
  output logic         handover
);
  localparam logic [N-1:0] DFLT_OH  = N'(1);
  localparam logic [N-1:0] GAP_MASK = {HANDOVER_MASK[N-1:1], 1'b0};

  arb_phase_e   phase_q, phase_d;
  logic [N-1:0] gnt_q, gnt_d;
  logic         owner_locked;
  logic         win_is_new;
  logic         win_needs_gap;

  assign owner_locked  = |(lock & gnt_q);
  assign win_is_new    = ~(|(win_oh & gnt_q));
  assign win_needs_gap = win_is_new & (|(win_oh & GAP_MASK));

  always_comb begin
    phase_d = PH_OWN;
    gnt_d   = gnt_q;
    if (phase_q == PH_GAP) begin
      gnt_d = win_oh;
    end else if (!owner_locked) begin
      if (win_needs_gap) begin
        gnt_d   = DFLT_OH;
        phase_d = PH_GAP;
      end else begin
        gnt_d = win_oh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= DFLT_OH;
      phase_q <= PH_OWN;
    end else begin
      gnt_q   <= gnt_d;
      phase_q <= phase_d;
    end
  end

  assign gnt      = gnt_q;
  assign handover = (phase_q == PH_GAP);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int unsigned NUM_MASTERS = 6,
  parameter logic [NUM_MASTERS-1:0] HANDOVER_MASK = 6'b010100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] lock,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   handover
);
  logic [NUM_MASTERS-1:0] win_oh;

  arb_prio_pick #(.N(NUM_MASTERS)) u_pick (
    .req    (req),
    .win_oh (win_oh)
  );

  arb_grant_fsm #(
    .N             (NUM_MASTERS),
    .HANDOVER_MASK (HANDOVER_MASK)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .win_oh   (win_oh),
    .lock     (lock),
    .gnt      (gnt),
    .handover (handover)
  );
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int unsigned N = 6
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] lock,
  input logic [N-1:0] gnt,
  input logic         handover
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt) == 1);

  p_reset_default_r2: assert property (@(posedge clk)
    rst |=> (gnt == N'(1)) && !handover);

  p_idle_default_r4: assert property (@(posedge clk) disable iff (rst)
    (!handover && !(|(lock & gnt)) && (req == '0)) |=> (gnt == N'(1)));

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!handover && (|(lock & gnt))) |=> $stable(gnt));

  p_gap_default_r7: assert property (@(posedge clk) disable iff (rst)
    handover |-> (gnt == N'(1)));

  p_gap_single_r9: assert property (@(posedge clk) disable iff (rst)
    handover |=> !handover);
endmodule

bind bus_arbiter bus_arbiter_chk #(.N(NUM_MASTERS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .lock     (lock),
  .gnt      (gnt),
  .handover (handover)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
  localparam int unsigned N = 6;
  localparam logic [N-1:0] HO = 6'b010100;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] lock = '0;
  logic [N-1:0] gnt;
  logic         handover;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_gnt = 6'b000001;
  logic         m_gap = 1'b0;

  bus_arbiter #(.NUM_MASTERS(N), .HANDOVER_MASK(HO)) u_dut (
    .clk(clk), .rst(rst), .req(req), .lock(lock), .gnt(gnt), .handover(handover)
  );

  always #10 clk = ~clk;

  function automatic logic [N-1:0] pick(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
    return N'(1);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] g_exp, input logic h_exp);
    checks++;
    if (gnt !== g_exp || handover !== h_exp) begin
      errors++;
      $display("FAIL %s: gnt=%b handover=%b expected gnt=%b handover=%b",
               tag, gnt, handover, g_exp, h_exp);
    end
  endtask

  // Apply inputs, advance one edge, update the reference, compare.
  task automatic cycle(input string tag, input logic r, input logic [N-1:0] rq,
                       input logic [N-1:0] lk);
    logic [N-1:0] w;
    rst = r; req = rq; lock = lk;
    w = pick(rq);
    if (r) begin
      m_gnt = 1; m_gap = 0;
    end else if (m_gap) begin
      m_gnt = w; m_gap = 0;
    end else if (!(|(lk & m_gnt))) begin
      if (((w & m_gnt) == '0) && (|(w & HO & ~N'(1)))) begin
        m_gnt = 1; m_gap = 1;
      end else m_gnt = w;
    end
    @(posedge clk); #1;
    check(tag, m_gnt, m_gap);
  endtask

  task automatic t_reset();
    cycle("R2 reset with all requests", 1, '1, '1);
    cycle("R2 reset held", 1, 6'b100000, 6'b100000);
    cycle("R1 first cycle after reset", 0, '0, '0);
  endtask

  task automatic t_idle();
    cycle("R4 idle gives default", 0, '0, '0);
    check("R4 idle value", 6'b000001, 1'b0);
  endtask

  task automatic t_priority();
    cycle("R3 111110", 0, 6'b111110, '0);
    check("R3 111110 gives 000010", 6'b000010, 1'b0);
    cycle("R3 011101", 0, 6'b011101, '0);
    check("R3 011101 gives 000001", 6'b000001, 1'b0);
    cycle("R8 direct to master 3", 0, 6'b101000, '0);
    check("R8 no gap for master 3", 6'b001000, 1'b0);
    // R10: request change between edges leaves gnt alone
    req = 6'b100000; #5;
    check("R10 gnt stable before edge", 6'b001000, 1'b0);
    cycle("R3 lone master 5", 0, 6'b100000, '0);
  endtask

  task automatic t_handover();
    cycle("R4 back to default", 0, '0, '0);
    cycle("R7 gap toward master 2", 0, 6'b000100, '0);
    check("R7 gap shows default", 6'b000001, 1'b1);
    cycle("R9 gap ends on master 2", 0, 6'b000100, '0);
    check("R9 master 2 granted", 6'b000100, 1'b0);
    cycle("R7 gap toward master 4", 0, 6'b010000, '0);
    check("R7 gap before master 4", 6'b000001, 1'b1);
    cycle("R9 winner re-picked at gap end", 0, 6'b000010, '0);
    check("R9 master 1 after gap", 6'b000010, 1'b0);
    cycle("R8 no gap into master 0", 0, 6'b000001, '0);
  endtask

  task automatic t_lock();
    cycle("R3 master 5 owns", 0, 6'b100000, '0);
    for (int k = 0; k < 3; k++) cycle("R5 owner lock holds", 0, 6'b000011, 6'b100000);
    check("R5 still master 5", 6'b100000, 1'b0);
    cycle("R6 foreign lock ignored", 0, 6'b000010, 6'b000010);
    check("R6 grant moved to master 1", 6'b000010, 1'b0);
    cycle("R5 master 1 locks", 0, 6'b000001, 6'b000010);
    cycle("R5 lock released", 0, 6'b000001, '0);
    check("R5 default after release", 6'b000001, 1'b0);
    cycle("R7 gap despite default lock off", 0, 6'b010000, '0);
    cycle("R9 lock during gap", 0, 6'b010000, 6'b000001);
    cycle("R5 master 4 locked", 0, 6'b000001, 6'b010000);
  endtask

  task automatic t_reset_mid();
    cycle("R2 reset mid-ownership", 1, '1, 6'b010000);
    check("R2 forced default", 6'b000001, 1'b0);
    cycle("R3 after reset", 0, 6'b001010, '0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: expired actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_idle();
    t_priority();
    t_handover();
    t_lock();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule